// File: doc/BRIEF.md
# Load-Tracking Frequency Scaling Controller

This block decides when a processor's clock should move between three performance levels, based on how busy the chip is. On each sample tick it reads sixteen single-bit activity inputs. Each input has a 3-bit weight and a detect mode, and the block adds the weights of the inputs that count into one load sample. The block then smooths the sample with an exponential moving average and compares the average with three thresholds: one for raising the frequency, one for lowering it and one for a panic.

Hysteresis counters require a set number of consecutive crossings before the block asks for a faster or slower level. A panic acts on the first crossing and forces the fastest level. When a request is issued, the block moves its level index, gives a one-cycle pulse naming the kind of request, and holds a busy flag until the clock system returns an acknowledge.

Level 0 is the fastest, level 2 is the slowest, and level 1 is the level after reset. The recommended configuration is:

- weight 7 on inputs 12 to 15 and weight 0 on the other inputs;
- an averaging count of 32 (shift 5);
- thresholds of 30 (up), 18 (down) and 63 (panic);
- run counts of 72 (up) and 51 (down).

All settings are plain inputs and are expected to stay stable while they are in use. None of the pins is a data stream, so there is no back-pressure: the tick is a strobe, and the acknowledge is the only input that answers a request.

Top module: `lt_freq_ctrl`

## Requirements
- R1: After reset, the level is 1, busy is 0 and the up, down and panic pulses are 0.
- R2: On a tick, the sample is min(63, 2 × S), where S is the sum of the weights of the inputs that count. The weight of input i is in weight_i bits [3i+2:3i]. An input with weight 0 never changes the sample.
- R3: If mode_i bit i is 0, input i counts whenever it is high at the tick. If the bit is 1, input i counts only when it is high at this tick and was low at the previous tick. The stored previous value is 0 after reset.
- R4: The average is held as a 14-bit value with 8 fraction bits. On each tick, acc becomes acc + (((sample << 8) − acc) >>> ema_log2_i), where >>> is an arithmetic shift that rounds toward minus infinity. The compared average is the integer part of acc.
- R5: An up request is issued when the average has been above up_thr_i at up_cnt_i consecutive evaluations. A count of 0 acts as 1. The request gives an up pulse and lowers the level index by one.
- R6: A down request is issued when the average has been below dn_thr_i at dn_cnt_i consecutive evaluations. The request gives a down pulse and raises the level index by one.
- R7: An evaluation where the average is not above the up threshold clears the up run. An evaluation where the average is not below the down threshold clears the down run.
- R8: If the average is above pnc_thr_i at an evaluation, the block issues a panic pulse and sets the level to 0. In that case no up or down pulse is issued.
- R9: An up request at level 0 and a down request at level 2 are suppressed. No pulse is issued and the level does not change.
- R10: Busy goes high together with any pulse and stays high until ack_i is sampled. While busy is high, evaluations issue nothing and leave the runs unchanged. An ack_i while busy is low has no effect.
- R11: Each evaluation happens one cycle after the tick, and each pulse lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Sample-enable strobe |
| act_i | input | 16 | Activity inputs |
| mode_i | input | 16 | Per-input detect mode (0 level, 1 rising) |
| weight_i | input | 48 | Per-input 3-bit weights |
| ema_log2_i | input | 3 | log2 of the averaging count |
| up_thr_i | input | 6 | Up threshold |
| dn_thr_i | input | 6 | Down threshold |
| pnc_thr_i | input | 6 | Panic threshold |
| up_cnt_i | input | 8 | Consecutive crossings needed for up |
| dn_cnt_i | input | 8 | Consecutive crossings needed for down |
| ack_i | input | 1 | Acknowledge of the pending request |
| level_o | output | 2 | Current performance level |
| up_req_o | output | 1 | Up request pulse |
| dn_req_o | output | 1 | Down request pulse |
| panic_req_o | output | 1 | Panic request pulse |
| busy_o | output | 1 | Request awaiting acknowledge |

## Verification
The hardest state to reach from the ports is a run of crossings that meets the exact run count while the block is busy, or while the level already sits at the limit in that direction. With the default averaging, the average moves by fractions, so it is difficult to place it on a given side of a threshold at a chosen tick. The stimulus therefore mostly sets the averaging shift to 0, so each tick sets the average directly to the sample. Thresholds are placed exactly at the sample to probe the strict comparisons. One scenario uses shift 1, so the fractional accumulator reaches a threshold only on a known tick.

// File: rtl/lt_pkg.sv
package lt_pkg;
  localparam int LT_CH      = 16;
  localparam int LT_WGT_W   = 3;
  localparam int LT_LOAD_W  = 6;
  localparam int LT_FRAC_W  = 8;
  localparam int LT_CNT_W   = 8;
  localparam int LT_SH_W    = 3;
  localparam int LT_LEVELS  = 3;

  // Result of one evaluation.
  typedef enum logic [1:0] {
    ACT_NONE  = 2'd0,
    ACT_UP    = 2'd1,
    ACT_DN    = 2'd2,
    ACT_PANIC = 2'd3
  } lt_act_e;
endpackage

// File: rtl/lt_load_sum.sv
module lt_load_sum #(
  parameter int CH         = 16,
  parameter int WGT_W      = 3,
  parameter int LOAD_W     = 6,
  parameter int LOAD_SHIFT = 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick_i,
  input  logic [CH-1:0]         act_i,
  input  logic [CH-1:0]         mode_i,
  input  logic [CH*WGT_W-1:0]   weight_i,
  output logic [LOAD_W-1:0]     sample_o
);
  localparam int SUM_W = WGT_W + $clog2(CH) + 1 + LOAD_SHIFT;
  localparam logic [SUM_W-1:0] SAT_LIM = SUM_W'((1 << LOAD_W) - 1);

  logic [CH-1:0]    prev_q;
  logic [WGT_W-1:0] contrib [CH];
  logic [SUM_W-1:0] sum, scaled;

  // Previous value of each input, captured at every tick (for rising-edge mode).
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      prev_q <= '0;
    else if (tick_i) prev_q <= act_i;
  end

  for (genvar g = 0; g < CH; g++) begin : g_ch
    logic hit;
    assign hit        = mode_i[g] ? (act_i[g] & ~prev_q[g]) : act_i[g];
    assign contrib[g] = hit ? weight_i[g*WGT_W +: WGT_W] : '0;
  end

  always_comb begin
    sum = '0;
    for (int i = 0; i < CH; i++) sum = sum + SUM_W'(contrib[i]);
    scaled = sum << LOAD_SHIFT;
    if (scaled > SAT_LIM) sample_o = '1;
    else                  sample_o = scaled[LOAD_W-1:0];
  end
endmodule

// File: rtl/lt_ema.sv
module lt_ema #(
  parameter int LOAD_W = 6,
  parameter int FRAC_W = 8,
  parameter int SH_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic [LOAD_W-1:0] sample_i,
  input  logic [SH_W-1:0]   log2_i,
  output logic [LOAD_W-1:0] avg_o
);
  localparam int A_W = LOAD_W + FRAC_W;

  logic [A_W-1:0]      acc_q;
  logic signed [A_W:0] tgt, diff, step;

  // Shift-based update: acc += (target - acc) >>> log2.
  always_comb begin
    tgt  = $signed({1'b0, sample_i, {FRAC_W{1'b0}}});
    diff = tgt - $signed({1'b0, acc_q});
    step = diff >>> log2_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (tick_i) acc_q <= acc_q + step[A_W-1:0];
  end

  assign avg_o = acc_q[A_W-1:FRAC_W];
endmodule

// File: rtl/lt_decide.sv
module lt_decide
  import lt_pkg::*;
#(
  parameter int LOAD_W      = 6,
  parameter int CNT_W       = 8,
  parameter int NUM_LEVELS  = 3,
  parameter int RESET_LEVEL = 1,
  parameter int LVL_W       = $clog2(NUM_LEVELS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              eval_i,
  input  logic [LOAD_W-1:0] avg_i,
  input  logic [LOAD_W-1:0] up_thr_i,
  input  logic [LOAD_W-1:0] dn_thr_i,
  input  logic [LOAD_W-1:0] pnc_thr_i,
  input  logic [CNT_W-1:0]  up_cnt_i,
  input  logic [CNT_W-1:0]  dn_cnt_i,
  input  logic              ack_i,
  output logic [LVL_W-1:0]  level_o,
  output logic              up_o,
  output logic              dn_o,
  output logic              pnc_o,
  output logic              busy_o
);
  localparam logic [LVL_W-1:0] TOP_LVL = LVL_W'(NUM_LEVELS - 1);
  localparam logic [LVL_W-1:0] RST_LVL = LVL_W'(RESET_LEVEL);

  logic [CNT_W-1:0] up_run_q, dn_run_q, up_run_n, dn_run_n;
  logic [CNT_W-1:0] up_lim, dn_lim;
  logic [CNT_W:0]   up_inc, dn_inc;
  logic [LVL_W-1:0] lvl_q, lvl_n;
  logic             busy_q, busy_n;
  logic             above, below, over, up_hit, dn_hit;
  lt_act_e          act_n, act_q;

  always_comb begin
    above  = avg_i > up_thr_i;
    below  = avg_i < dn_thr_i;
    over   = avg_i > pnc_thr_i;
    up_lim = (up_cnt_i == '0) ? CNT_W'(1) : up_cnt_i;
    dn_lim = (dn_cnt_i == '0) ? CNT_W'(1) : dn_cnt_i;
    up_inc = {1'b0, up_run_q} + 1'b1;
    dn_inc = {1'b0, dn_run_q} + 1'b1;
    up_hit = above && (up_inc >= {1'b0, up_lim});
    dn_hit = below && (dn_inc >= {1'b0, dn_lim});

    up_run_n = up_run_q;
    dn_run_n = dn_run_q;
    lvl_n    = lvl_q;
    busy_n   = busy_q && !ack_i;
    act_n    = ACT_NONE;

    // Runs are frozen while a request waits for its acknowledge.
    if (eval_i && !busy_q) begin
      up_run_n = above ? up_inc[CNT_W-1:0] : '0;
      dn_run_n = below ? dn_inc[CNT_W-1:0] : '0;
      if (over) begin
        act_n    = ACT_PANIC;
        lvl_n    = '0;
        busy_n   = 1'b1;
        up_run_n = '0;
        dn_run_n = '0;
      end else if (up_hit) begin
        up_run_n = '0;
        if (lvl_q != '0) begin
          act_n    = ACT_UP;
          lvl_n    = lvl_q - 1'b1;
          busy_n   = 1'b1;
          dn_run_n = '0;
        end
      end else if (dn_hit) begin
        dn_run_n = '0;
        if (lvl_q != TOP_LVL) begin
          act_n    = ACT_DN;
          lvl_n    = lvl_q + 1'b1;
          busy_n   = 1'b1;
          up_run_n = '0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_run_q <= '0;
      dn_run_q <= '0;
      lvl_q    <= RST_LVL;
      busy_q   <= 1'b0;
      act_q    <= ACT_NONE;
    end else begin
      up_run_q <= up_run_n;
      dn_run_q <= dn_run_n;
      lvl_q    <= lvl_n;
      busy_q   <= busy_n;
      act_q    <= act_n;
    end
  end

  assign level_o = lvl_q;
  assign busy_o  = busy_q;
  assign up_o    = (act_q == ACT_UP);
  assign dn_o    = (act_q == ACT_DN);
  assign pnc_o   = (act_q == ACT_PANIC);
endmodule

// File: rtl/lt_freq_ctrl.sv
module lt_freq_ctrl
  import lt_pkg::*;
#(
  parameter int CH          = LT_CH,
  parameter int WGT_W       = LT_WGT_W,
  parameter int LOAD_W      = LT_LOAD_W,
  parameter int FRAC_W      = LT_FRAC_W,
  parameter int CNT_W       = LT_CNT_W,
  parameter int SH_W        = LT_SH_W,
  parameter int LOAD_SHIFT  = 1,
  parameter int NUM_LEVELS  = LT_LEVELS,
  parameter int RESET_LEVEL = 1,
  localparam int LVL_W      = $clog2(NUM_LEVELS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick_i,
  input  logic [CH-1:0]        act_i,
  input  logic [CH-1:0]        mode_i,
  input  logic [CH*WGT_W-1:0]  weight_i,
  input  logic [SH_W-1:0]      ema_log2_i,
  input  logic [LOAD_W-1:0]    up_thr_i,
  input  logic [LOAD_W-1:0]    dn_thr_i,
  input  logic [LOAD_W-1:0]    pnc_thr_i,
  input  logic [CNT_W-1:0]     up_cnt_i,
  input  logic [CNT_W-1:0]     dn_cnt_i,
  input  logic                 ack_i,
  output logic [LVL_W-1:0]     level_o,
  output logic                 up_req_o,
  output logic                 dn_req_o,
  output logic                 panic_req_o,
  output logic                 busy_o
);
  logic [LOAD_W-1:0] sample, avg;
  logic              eval_q;

  lt_load_sum #(
    .CH(CH), .WGT_W(WGT_W), .LOAD_W(LOAD_W), .LOAD_SHIFT(LOAD_SHIFT)
  ) u_sum (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .act_i(act_i),
    .mode_i(mode_i), .weight_i(weight_i), .sample_o(sample)
  );

  lt_ema #(
    .LOAD_W(LOAD_W), .FRAC_W(FRAC_W), .SH_W(SH_W)
  ) u_ema (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .sample_i(sample),
    .log2_i(ema_log2_i), .avg_o(avg)
  );

  // The average updates at the tick edge; it is judged one cycle later.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) eval_q <= 1'b0;
    else        eval_q <= tick_i;
  end

  lt_decide #(
    .LOAD_W(LOAD_W), .CNT_W(CNT_W), .NUM_LEVELS(NUM_LEVELS),
    .RESET_LEVEL(RESET_LEVEL), .LVL_W(LVL_W)
  ) u_dec (
    .clk(clk), .rst_n(rst_n), .eval_i(eval_q), .avg_i(avg),
    .up_thr_i(up_thr_i), .dn_thr_i(dn_thr_i), .pnc_thr_i(pnc_thr_i),
    .up_cnt_i(up_cnt_i), .dn_cnt_i(dn_cnt_i), .ack_i(ack_i),
    .level_o(level_o), .up_o(up_req_o), .dn_o(dn_req_o),
    .pnc_o(panic_req_o), .busy_o(busy_o)
  );
endmodule

// File: rtl/lt_freq_ctrl_chk.sv
module lt_freq_ctrl_chk #(
  parameter int NUM_LEVELS = 3,
  parameter int LVL_W      = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [LVL_W-1:0] level_o,
  input logic             up_req_o,
  input logic             dn_req_o,
  input logic             panic_req_o,
  input logic             busy_o
);
  logic any_req;
  assign any_req = up_req_o | dn_req_o | panic_req_o;

  AST_ONE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({up_req_o, dn_req_o, panic_req_o})); // R8
  AST_PANIC_FASTEST: assert property (@(posedge clk) disable iff (!rst_n)
    panic_req_o |-> (level_o == '0)); // R8
  AST_UP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    up_req_o |-> (level_o == $past(level_o) - 1'b1)); // R5
  AST_DN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    dn_req_o |-> (level_o == $past(level_o) + 1'b1)); // R6
  AST_LEVEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    level_o < LVL_W'(NUM_LEVELS)); // R9
  AST_LEVEL_MOVES_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (level_o != $past(level_o)) |-> any_req); // R9
  AST_BUSY_WITH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    any_req |-> busy_o); // R10
  AST_QUIET_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> !any_req); // R10
  AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    any_req |=> !any_req); // R11
endmodule

bind lt_freq_ctrl lt_freq_ctrl_chk #(
  .NUM_LEVELS(NUM_LEVELS), .LVL_W(LVL_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .level_o(level_o), .up_req_o(up_req_o),
  .dn_req_o(dn_req_o), .panic_req_o(panic_req_o), .busy_o(busy_o)
);

// File: tb/lt_freq_ctrl_tb.sv
module lt_freq_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [15:0] act = '0;
  logic [15:0] mode = '0;
  logic [47:0] wt = '0;
  logic [2:0]  k = 3'd5;
  logic [5:0]  up_thr = 6'd30, dn_thr = 6'd18, pnc_thr = 6'd63;
  logic [7:0]  up_cnt = 8'd72, dn_cnt = 8'd51;
  logic        ack = 1'b0;
  logic [1:0]  level;
  logic        up, dn, pnc, busy;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  lt_freq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .act_i(act), .mode_i(mode),
    .weight_i(wt), .ema_log2_i(k), .up_thr_i(up_thr), .dn_thr_i(dn_thr),
    .pnc_thr_i(pnc_thr), .up_cnt_i(up_cnt), .dn_cnt_i(dn_cnt), .ack_i(ack),
    .level_o(level), .up_req_o(up), .dn_req_o(dn), .panic_req_o(pnc),
    .busy_o(busy)
  );

  task automatic chk(input string req, input int actual, input int expect_v);
    checks++;
    if (actual != expect_v) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, actual, expect_v);
    end
  endtask

  // Back to the recommended setup, inputs idle, reset pulsed.
  task automatic apply_reset();
    rst_n = 1'b0; tick = 0; ack = 0; act = '0; mode = '0;
    wt = {{4{3'd7}}, 36'd0}; k = 3'd5;
    up_thr = 6'd30; dn_thr = 6'd18; pnc_thr = 6'd63;
    up_cnt = 8'd72; dn_cnt = 8'd51;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // Tick for one cycle; return at the negedge where the decision is visible.
  task automatic tick_look();
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_ack(input string req);
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    chk({req, " busy after ack"}, busy, 0);
  endtask

  task automatic t_reset();
    apply_reset();
    chk("R1 level", level, 1);
    chk("R1 busy", busy, 0);
    chk("R1 pulses", {up, dn, pnc}, 0);
  endtask

  task automatic t_weights();
    apply_reset();
    k = 0; up_cnt = 8'd0;             // count 0 acts as 1 (R5)
    wt[12*3 +: 3] = 3'd7; wt[13*3 +: 3] = 3'd7; wt[14*3 +: 3] = 3'd1;
    act = 16'h7001;                   // input 0 has weight 0
    up_thr = 6'd30;                   // sample 2*15 = 30, not above
    tick_look();
    chk("R2 sample 30 not above 30", up, 0);
    up_thr = 6'd29;
    tick_look();
    chk("R2 R5 sample 30 above 29", up, 1);
    chk("R5 level after up", level, 0);
    // Saturation at 63.
    apply_reset();
    k = 0; wt = {16{3'd7}}; act = 16'hFFFF; pnc_thr = 6'd62;
    tick_look();
    chk("R2 saturated sample above 62", pnc, 1);
    apply_reset();
    k = 0; wt = {16{3'd7}}; act = 16'hFFFF; pnc_thr = 6'd63;
    tick_look();
    chk("R2 saturated sample not above 63", pnc, 0);
  endtask

  task automatic t_edge();
    apply_reset();
    k = 0; dn_thr = 6'd10; dn_cnt = 8'd1; mode[12] = 1'b1;
    act[12] = 1'b1;
    tick_look();
    chk("R3 rising edge counts", dn, 0);
    tick_look();
    chk("R3 held high ignored in edge mode", dn, 1);
    chk("R3 level", level, 2);
    apply_reset();
    k = 0; dn_thr = 6'd10; dn_cnt = 8'd1;
    act[12] = 1'b1;
    tick_look();
    tick_look();
    chk("R3 level mode keeps counting", dn, 0);
  endtask

  task automatic t_ema();
    apply_reset();
    k = 3'd1; up_cnt = 8'd1; up_thr = 6'd34;
    wt[14*3 +: 3] = 3'd6; act = 16'h7000;  // sample 40; avg 20, 30, 35
    tick_look();
    chk("R4 avg 20", up, 0);
    tick_look();
    chk("R4 avg 30", up, 0);
    tick_look();
    chk("R4 avg 35 above 34", up, 1);
  endtask

  task automatic t_up_run();
    apply_reset();
    k = 0; up_cnt = 8'd3; act = 16'hF000;   // sample 56
    tick_look(); chk("R5 run 1", up, 0);
    tick_look(); chk("R5 run 2", up, 0);
    act = '0;
    tick_look(); chk("R7 run broken", up, 0);
    act = 16'hF000;
    tick_look(); chk("R7 restart 1", up, 0);
    tick_look(); chk("R7 restart 2", up, 0);
    tick_look(); chk("R5 third crossing", up, 1);
    chk("R5 level", level, 0);
  endtask

  task automatic t_down();
    apply_reset();
    k = 0; dn_cnt = 8'd2;
    tick_look(); chk("R6 run 1", dn, 0);
    tick_look(); chk("R6 second crossing", dn, 1);
    chk("R6 level", level, 2);
    do_ack("R10");
    tick_look(); tick_look();
    chk("R9 down at slowest", dn, 0);
    chk("R9 level stays slowest", level, 2);
    pnc_thr = 6'd50; up_cnt = 8'd1; act = 16'hF000;
    tick_look();
    chk("R8 panic pulse", pnc, 1);
    chk("R8 no up with panic", up, 0);
    chk("R8 level forced", level, 0);
    do_ack("R10");
    pnc_thr = 6'd63;
    tick_look();
    chk("R9 up at fastest", up, 0);
    chk("R9 level stays fastest", level, 0);
  endtask

  task automatic t_busy();
    apply_reset();
    k = 0; up_cnt = 8'd1; dn_cnt = 8'd1; act = 16'hF000;
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    chk("R11 no pulse before evaluation", up, 0);
    @(negedge clk);
    chk("R11 up pulse", up, 1);
    chk("R10 busy with pulse", busy, 1);
    @(negedge clk);
    chk("R11 pulse one cycle", up, 0);
    act = '0;
    tick_look();
    chk("R10 no down while busy", dn, 0);
    chk("R10 level held", level, 0);
    chk("R10 busy held", busy, 1);
    do_ack("R10");
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    chk("R10 idle ack no effect", {level, up, dn, pnc, busy}, 0);
    tick_look();
    chk("R10 down after ack", dn, 1);
    chk("R10 level", level, 1);
  endtask

  initial begin
    t_reset();
    t_weights();
    t_edge();
    t_ema();
    t_up_run();
    t_down();
    t_busy();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule